// File: doc/BRIEF.md
# Inverted Mesh Next-Hop Router

This block makes the routing decision for one processor of a square inverted mesh of side `SIDE`. Every node has the four axis links of an ordinary mesh. It also has one pair of diagonal links. Diagonals cross only every other square of the grid, so the pair a node owns depends on the parity of its coordinates. A node whose x and y have the same parity owns the NE/SW pair. A node with mixed parity owns the NW/SE pair.

A request strobe captures the local and target coordinates. The unit then reports the neighbour set of the local node and the orientation of its diagonal pair. It also walks the greedy route internally, one hop per clock, to find the first output direction and the number of hops that remain. When the walk ends, a one-cycle valid pulse is issued, and the results stay on the outputs until the next result. A coordinate outside the grid raises an error flag, and no direction is given.

Top module: `imn_router`

## Requirements
- R1: A request seen while idle captures all four coordinates. For a route of H hops, `valid` is high for exactly one cycle, H+1 clock edges after the capture edge. An error or a zero-hop request therefore takes 1 edge. All outputs hold their values until the next result.
- R2: A request that arrives while a route is being walked has no effect: neither the result nor the neighbour set changes.
- R3: `diag_ne_sw` is 1 when the captured local x and y have equal parity (the node owns the NE/SW diagonals). It is 0 when their parities differ (the node owns NW/SE).
- R4: `nbr_mask` uses these bit positions: 0=N (y+1), 1=S (y-1), 2=E (x+1), 3=W (x-1), 4=NE, 5=NW, 6=SE, 7=SW. A bit is set only when the node owns that link and the link stays inside the grid. The four axis bits are owned by every node. The two diagonals are owned according to R3.
- R5: When both offsets to the target are nonzero and the node owns the diagonal that points toward the target in both axes, the first step is that diagonal.
- R6: Otherwise, the first step is along the axis with the larger absolute offset, and a tie goes to x.
- R7: `step_dir` uses the bit positions of R4. It has at most one bit set, and it is all zeros when the target equals the local node.
- R8: `hops` equals the length of the route that applies R5/R6 at every node it visits. In a 4x4 grid, node (0,0) reaches (3,3) in 3 hops.
- R9: If any captured coordinate is SIDE or larger, the result has `route_err`=1, `step_dir`=0 and `hops`=0. If the local coordinate is the one out of range, `nbr_mask` is 0.
- R10: After reset, `valid`, `route_err`, `step_dir` and `hops` are 0. The outputs describe node (0,0): `nbr_mask`=8'h15 and `diag_ne_sw`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe; captures coordinates when idle |
| loc_x | input | PW | Local x coordinate |
| loc_y | input | PW | Local y coordinate |
| dst_x | input | PW | Target x coordinate |
| dst_y | input | PW | Target y coordinate |
| valid | output | 1 | One-cycle result pulse |
| route_err | output | 1 | A coordinate was outside the grid |
| step_dir | output | 8 | One-hot first-hop direction |
| hops | output | HW | Hop count of the greedy route |
| diag_ne_sw | output | 1 | Local node owns the NE/SW diagonals |
| nbr_mask | output | 8 | Links present at the local node |

## Verification
Every in-range pair of local and target nodes in a 4x4 grid is applied. This separates diagonal steps that match the node's parity from those the node lacks, axis steps with a larger x or y offset and with ties, and zero-hop requests. Each pair also checks latency against the expected hop count. A second sweep mixes in out-of-range local and target values, which separates local-side errors (mask cleared) from target-side errors. A request fired in the middle of a long walk shows that a busy unit ignores new input.

// File: rtl/imn_pkg.sv
package imn_pkg;
   localparam int NDIR   = 8;
   localparam int DIR_N  = 0;
   localparam int DIR_S  = 1;
   localparam int DIR_E  = 2;
   localparam int DIR_W  = 3;
   localparam int DIR_NE = 4;
   localparam int DIR_NW = 5;
   localparam int DIR_SE = 6;
   localparam int DIR_SW = 7;
   typedef logic [NDIR-1:0] dir_vec_t;
endpackage

// File: rtl/imn_coord_chk.sv
module imn_coord_chk #(
   parameter int SIDE = 4,
   parameter int PW   = $clog2(SIDE) + 1
) (
   input  logic [PW-1:0] c,
   output logic          ok
);
   localparam int CW = $clog2(SIDE);

   if (SIDE < 2) begin : g_bad_side
      $error("imn_coord_chk: SIDE must be at least 2");
   end
   if (PW <= CW) begin : g_bad_pw
      $error("imn_coord_chk: PW must exceed clog2(SIDE)");
   end

   // power-of-two grids only need the bits above the coordinate range
   if ((1 << CW) == SIDE) begin : g_pow2
      assign ok = ~|(c >> CW);
   end else begin : g_generic
      assign ok = (c < PW'(SIDE));
   end
endmodule

// File: rtl/imn_link_map.sv
module imn_link_map
   import imn_pkg::*;
#(
   parameter int SIDE = 4,
   parameter int PW   = $clog2(SIDE) + 1
) (
   input  logic [PW-1:0] x,
   input  logic [PW-1:0] y,
   output dir_vec_t      links,
   output logic          ne_sw
);
   localparam logic [PW-1:0] EDGE = PW'(SIDE - 1);

   logic up, dn, rt, lf;

   assign up    = (y < EDGE);
   assign dn    = (y != '0);
   assign rt    = (x < EDGE);
   assign lf    = (x != '0);
   assign ne_sw = ~(x[0] ^ y[0]);

   always_comb begin
      links         = '0;
      links[DIR_N]  = up;
      links[DIR_S]  = dn;
      links[DIR_E]  = rt;
      links[DIR_W]  = lf;
      links[DIR_NE] = ne_sw  & rt & up;
      links[DIR_SW] = ne_sw  & lf & dn;
      links[DIR_NW] = ~ne_sw & lf & up;
      links[DIR_SE] = ~ne_sw & rt & dn;
   end
endmodule

// File: rtl/imn_step_select.sv
module imn_step_select
   import imn_pkg::*;
#(
   parameter int SIDE = 4,
   parameter int PW   = $clog2(SIDE) + 1
) (
   input  logic [PW-1:0] cur_x,
   input  logic [PW-1:0] cur_y,
   input  logic [PW-1:0] tgt_x,
   input  logic [PW-1:0] tgt_y,
   output dir_vec_t      step,
   output logic [PW-1:0] nxt_x,
   output logic [PW-1:0] nxt_y
);
   localparam int SW = PW + 1;

   logic signed [SW-1:0] dx, dy;
   logic        [SW-1:0] mag_x, mag_y;
   logic                 even_node, both_off, same_sign;

   assign dx        = $signed({1'b0, tgt_x}) - $signed({1'b0, cur_x});
   assign dy        = $signed({1'b0, tgt_y}) - $signed({1'b0, cur_y});
   assign mag_x     = dx[SW-1] ? SW'(-dx) : SW'(dx);
   assign mag_y     = dy[SW-1] ? SW'(-dy) : SW'(dy);
   assign even_node = ~(cur_x[0] ^ cur_y[0]);
   assign both_off  = (dx != '0) && (dy != '0);
   assign same_sign = (dx[SW-1] == dy[SW-1]);

   always_comb begin
      step = '0;
      if (dx == '0 && dy == '0) begin
         step = '0;
      end else if (both_off && same_sign && even_node) begin
         if (dx[SW-1]) step[DIR_SW] = 1'b1;
         else          step[DIR_NE] = 1'b1;
      end else if (both_off && !same_sign && !even_node) begin
         if (dx[SW-1]) step[DIR_NW] = 1'b1;
         else          step[DIR_SE] = 1'b1;
      end else if (mag_x >= mag_y) begin
         if (dx[SW-1]) step[DIR_W] = 1'b1;
         else          step[DIR_E] = 1'b1;
      end else begin
         if (dy[SW-1]) step[DIR_S] = 1'b1;
         else          step[DIR_N] = 1'b1;
      end
   end

   always_comb begin
      nxt_x = cur_x;
      nxt_y = cur_y;
      if (step[DIR_E] | step[DIR_NE] | step[DIR_SE]) nxt_x = cur_x + PW'(1);
      if (step[DIR_W] | step[DIR_NW] | step[DIR_SW]) nxt_x = cur_x - PW'(1);
      if (step[DIR_N] | step[DIR_NE] | step[DIR_NW]) nxt_y = cur_y + PW'(1);
      if (step[DIR_S] | step[DIR_SE] | step[DIR_SW]) nxt_y = cur_y - PW'(1);
   end
endmodule

// File: rtl/imn_router.sv
module imn_router
   import imn_pkg::*;
#(
   parameter int SIDE = 4,
   parameter int PW   = $clog2(SIDE) + 1,
   parameter int HW   = $clog2(2 * SIDE - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [PW-1:0] loc_x,
   input  logic [PW-1:0] loc_y,
   input  logic [PW-1:0] dst_x,
   input  logic [PW-1:0] dst_y,
   output logic          valid,
   output logic          route_err,
   output logic [7:0]    step_dir,
   output logic [HW-1:0] hops,
   output logic          diag_ne_sw,
   output logic [7:0]    nbr_mask
);
   localparam int MAX_HOPS = 2 * (SIDE - 1);

   if (SIDE < 2) begin : g_bad_side
      $error("imn_router: SIDE must be at least 2");
   end
   if ((1 << HW) <= MAX_HOPS) begin : g_bad_hw
      $error("imn_router: HW too narrow for the longest route");
   end

   // input range checks, one per coordinate
   logic [3:0]    in_ok;
   logic [PW-1:0] in_c [4];
   assign in_c[0] = loc_x;
   assign in_c[1] = loc_y;
   assign in_c[2] = dst_x;
   assign in_c[3] = dst_y;

   for (genvar i = 0; i < 4; i++) begin : g_chk
      imn_coord_chk #(.SIDE(SIDE), .PW(PW)) u_chk (.c(in_c[i]), .ok(in_ok[i]));
   end

   // state
   logic [PW-1:0] home_x, home_y, cur_x, cur_y, tgt_x, tgt_y;
   logic          home_ok, bad, busy;
   logic [HW-1:0] hop_cnt;
   dir_vec_t      first_dir;
   logic          valid_q, err_q;
   dir_vec_t      dir_q;
   logic [HW-1:0] hops_q;

   dir_vec_t      step;
   logic [PW-1:0] nxt_x, nxt_y;
   logic          arrived;

   imn_step_select #(.SIDE(SIDE), .PW(PW)) u_step (
      .cur_x(cur_x), .cur_y(cur_y), .tgt_x(tgt_x), .tgt_y(tgt_y),
      .step(step), .nxt_x(nxt_x), .nxt_y(nxt_y)
   );

   assign arrived = (cur_x == tgt_x) && (cur_y == tgt_y);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         home_x    <= '0;
         home_y    <= '0;
         cur_x     <= '0;
         cur_y     <= '0;
         tgt_x     <= '0;
         tgt_y     <= '0;
         home_ok   <= 1'b1;
         bad       <= 1'b0;
         busy      <= 1'b0;
         hop_cnt   <= '0;
         first_dir <= '0;
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
         dir_q     <= '0;
         hops_q    <= '0;
      end else if (!busy) begin
         valid_q <= 1'b0;
         if (req) begin
            home_x    <= loc_x;
            home_y    <= loc_y;
            cur_x     <= loc_x;
            cur_y     <= loc_y;
            tgt_x     <= dst_x;
            tgt_y     <= dst_y;
            home_ok   <= in_ok[0] & in_ok[1];
            bad       <= ~&in_ok;
            busy      <= 1'b1;
            hop_cnt   <= '0;
            first_dir <= '0;
         end
      end else if (bad || arrived) begin
         busy    <= 1'b0;
         valid_q <= 1'b1;
         err_q   <= bad;
         dir_q   <= bad ? '0 : first_dir;
         hops_q  <= bad ? '0 : hop_cnt;
      end else begin
         cur_x   <= nxt_x;
         cur_y   <= nxt_y;
         hop_cnt <= hop_cnt + HW'(1);
         if (hop_cnt == '0) first_dir <= step;
      end
   end

   // neighbour set of the captured local node
   dir_vec_t home_links;
   logic     home_ne_sw;
   imn_link_map #(.SIDE(SIDE), .PW(PW)) u_home_map (
      .x(home_x), .y(home_y), .links(home_links), .ne_sw(home_ne_sw)
   );

   assign valid      = valid_q;
   assign route_err  = err_q;
   assign step_dir   = dir_q;
   assign hops       = hops_q;
   assign diag_ne_sw = home_ne_sw;
   assign nbr_mask   = home_ok ? home_links : '0;

   // link map of the walking position, used only to police the walker
   dir_vec_t cur_links;
   logic     cur_ne_sw;
   imn_link_map #(.SIDE(SIDE), .PW(PW)) u_cur_map (
      .x(cur_x), .y(cur_y), .links(cur_links), .ne_sw(cur_ne_sw)
   );

   // R1: result pulse lasts one cycle
   assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R1: result held until next completion
   assert_result_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid && !$past(busy) |-> $stable(step_dir) && $stable(hops));

   // R2: a request while busy does not disturb the captured local node
   assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && req |=> $stable(home_x) && $stable(home_y));

   // R4: each step of the walk uses a link the current node owns
   assert_step_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bad && !arrived |-> (step & ~cur_links) == '0);

   // R5: a diagonal step matches the owned diagonal pair
   assert_diag_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bad && (step[DIR_NE] | step[DIR_SW]) |-> cur_ne_sw);

   // R7: direction is one-hot or empty
   assert_dir_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $onehot0(step_dir));

   // R7: zero hops means no direction
   assert_zero_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !route_err && hops == '0 |-> step_dir == '0);

   // R8: the walk never exceeds the longest possible route
   assert_hop_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> hop_cnt <= HW'(MAX_HOPS));

   // R9: an error result carries no direction and no hops
   assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && route_err |-> step_dir == '0 && hops == '0);
endmodule

// File: tb/imn_router_test.sv
module imn_router_test;
   localparam int SIDE = 4;
   localparam int PW   = 3;
   localparam int HW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [PW-1:0] loc_x = '0, loc_y = '0, dst_x = '0, dst_y = '0;
   logic          valid, route_err, diag_ne_sw;
   logic [7:0]    step_dir, nbr_mask;
   logic [HW-1:0] hops;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   imn_router #(.SIDE(SIDE), .PW(PW), .HW(HW)) uut (
      .clk(clk), .rst_n(rst_n), .req(req),
      .loc_x(loc_x), .loc_y(loc_y), .dst_x(dst_x), .dst_y(dst_y),
      .valid(valid), .route_err(route_err), .step_dir(step_dir),
      .hops(hops), .diag_ne_sw(diag_ne_sw), .nbr_mask(nbr_mask)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // direction bits: 0 N,1 S,2 E,3 W,4 NE,5 NW,6 SE,7 SW
   function automatic int model_dir(int cx, int cy, int tx, int ty);
      int dx = tx - cx;
      int dy = ty - cy;
      int ax = dx < 0 ? -dx : dx;
      int ay = dy < 0 ? -dy : dy;
      if (dx == 0 && dy == 0) return 0;
      if (dx != 0 && dy != 0) begin
         if ((cx + cy) % 2 == 0) begin
            if (dx > 0 && dy > 0) return 8'h10;
            if (dx < 0 && dy < 0) return 8'h80;
         end else begin
            if (dx < 0 && dy > 0) return 8'h20;
            if (dx > 0 && dy < 0) return 8'h40;
         end
      end
      if (ax >= ay) return dx > 0 ? 8'h04 : 8'h08;
      return dy > 0 ? 8'h01 : 8'h02;
   endfunction

   function automatic int model_hops(int cx, int cy, int tx, int ty);
      int h = 0;
      int x = cx;
      int y = cy;
      while (!(x == tx && y == ty) && h < 50) begin
         int d = model_dir(x, y, tx, ty);
         if (d & 8'h54) x++;
         if (d & 8'hA8) x--;
         if (d & 8'h31) y++;
         if (d & 8'hC2) y--;
         h++;
      end
      return h;
   endfunction

   function automatic int model_nbr(int x, int y);
      int m = 0;
      bit ev = ((x + y) % 2 == 0);
      if (y < SIDE - 1) m |= 8'h01;
      if (y > 0)        m |= 8'h02;
      if (x < SIDE - 1) m |= 8'h04;
      if (x > 0)        m |= 8'h08;
      if (ev  && x < SIDE - 1 && y < SIDE - 1) m |= 8'h10;
      if (!ev && x > 0 && y < SIDE - 1)        m |= 8'h20;
      if (!ev && x < SIDE - 1 && y > 0)        m |= 8'h40;
      if (ev  && x > 0 && y > 0)               m |= 8'h80;
      return m;
   endfunction

   task automatic apply(input int hx, input int hy, input int tx, input int ty);
      bit e_err  = (hx >= SIDE) || (hy >= SIDE) || (tx >= SIDE) || (ty >= SIDE);
      bit h_ok   = (hx < SIDE) && (hy < SIDE);
      int e_dir  = e_err ? 0 : model_dir(hx, hy, tx, ty);
      int e_hops = e_err ? 0 : model_hops(hx, hy, tx, ty);
      int e_nbr  = h_ok ? model_nbr(hx, hy) : 0;
      int n;
      int held;
      string dtag;
      loc_x = PW'(hx); loc_y = PW'(hy); dst_x = PW'(tx); dst_y = PW'(ty);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      n = 1;
      while (!valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(n == e_hops + 2, "R1 latency", n, e_hops + 2);
      chk(route_err == e_err, "R9 error flag", route_err, e_err);
      if (e_err)             dtag = "R9 direction";
      else if (e_dir == 0)   dtag = "R7 direction";
      else if (e_dir >= 16)  dtag = "R5 direction";
      else                   dtag = "R6 direction";
      chk(step_dir == 8'(e_dir), dtag, step_dir, e_dir);
      chk(hops == HW'(e_hops), "R8 hops", hops, e_hops);
      chk(nbr_mask == 8'(e_nbr), "R4 neighbour mask", nbr_mask, e_nbr);
      if (h_ok)
         chk(diag_ne_sw == ((hx + hy) % 2 == 0), "R3 diagonal pair",
             diag_ne_sw, ((hx + hy) % 2 == 0));
      held = step_dir;
      @(negedge clk);
      chk(!valid && step_dir == 8'(held), "R1 pulse and hold",
          {valid, step_dir}, held);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid && !route_err && step_dir == 0 && hops == 0,
          "R10 reset outputs", {valid, route_err, step_dir, hops}, 0);
      chk(nbr_mask == 8'h15 && diag_ne_sw, "R10 reset node view",
          {diag_ne_sw, nbr_mask}, 9'h115);

      // R8: corner to corner in 3 hops
      apply(0, 0, 3, 3);
      chk(hops == 3 && step_dir == 8'h10, "R8 corner route", {step_dir, hops}, {8'h10, 3'd3});

      // R2: request during a walk is ignored
      loc_x = 0; loc_y = 0; dst_x = 3; dst_y = 3;
      req = 1'b1;
      @(negedge clk);
      loc_x = 3; loc_y = 2; dst_x = 0; dst_y = 1;
      @(negedge clk);
      req = 1'b0;
      while (!valid) @(negedge clk);
      chk(step_dir == 8'h10 && hops == 3, "R2 busy request ignored",
          {step_dir, hops}, {8'h10, 3'd3});
      chk(nbr_mask == 8'h15, "R2 local node kept", nbr_mask, 8'h15);
      @(negedge clk);
      @(negedge clk);
      chk(!valid, "R2 no extra result", valid, 0);

      // exhaustive in-range sweep
      for (int hx = 0; hx < SIDE; hx++)
         for (int hy = 0; hy < SIDE; hy++)
            for (int tx = 0; tx < SIDE; tx++)
               for (int ty = 0; ty < SIDE; ty++)
                  apply(hx, hy, tx, ty);

      // out-of-range mix
      for (int hx = 0; hx < 8; hx++)
         for (int tx = 1; tx < 8; tx += 3)
            begin
               apply(hx, 0, tx, 2);
               apply(hx, 5, tx, 6);
            end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule